// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block gathers per-pin event pulses from several banks of GPIO pins and folds each bank into one interrupt group. Every group keeps a sticky source register that records events whether or not they are enabled, an enable mask that software changes only through write-one-to-set and write-one-to-clear addresses, and a read-only result equal to source AND enable. A global block-enable register holds one bit per group and gates that group's interrupt line toward the processor's interrupt controller.

Bit n of a group always corresponds to pin n of its bank. Software services a group by reading its result, then writing those bits back to the source address. Any bits still pending keep the line asserted, so no edge is lost between reading and clearing. Pin-level edge detection, the interrupt controller and the bus fabric sit outside the block. Group slot k drives line `irq[k]`, and the integration wires each line to its controller input.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, all source, enable and block-enable bits are 0, every `irq` bit is 0 and every register address reads 0.
- R2: A 1 on `pin_event[g*BANK_WIDTH+n]` at a clock edge sets source bit n of group g, even when its enable bit is 0. The bit stays set until software clears it.
- R3: A write to the source address of a group clears each source bit whose write-data bit is 1. Write-data bits that are 0 leave their source bits unchanged.
- R4: If an event and a write-one clear hit the same source bit at the same edge, the bit ends up set.
- R5: A write to the enable-set address sets each enable bit whose write-data bit is 1. Zeros leave enable bits unchanged.
- R6: A write to the enable-clear address clears each enable bit whose write-data bit is 1. Zeros leave enable bits unchanged.
- R7: The result address reads source AND enable for that group. Writes to the result address change nothing.
- R8: `irq[g]` is a level that is 1 exactly when block-enable bit g is 1 and at least one result bit of group g is 1.
- R9: The register map places group g at word address 4*g, with offset 0 for source, 1 for enable-set, 2 for enable-clear and 3 for result. Both the enable-set and enable-clear offsets read back the current enable mask. Address 4*NUM_GROUPS is the read/write block-enable register, where bit g controls group g. All other addresses read 0 and ignore writes.
- R10: Writing all ones to a group's source address with no event in that cycle clears every pending bit of the group, and its `irq` drops after that edge.
- R11: After a partial clear that leaves enabled bits pending, `irq` of that group stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_event | input | NUM_GROUPS*BANK_WIDTH | One-cycle event pulses. Group g occupies bits g*BANK_WIDTH and up |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wdata | input | BANK_WIDTH | Write data |
| reg_rdata | output | BANK_WIDTH | Read data for `reg_addr`, combinational from the registers |
| irq | output | NUM_GROUPS | One level interrupt line per group |

## Verification
The bench builds the block with its defaults: six groups of 32 bits and a 5-bit address. This puts the top bit of a bank, the last group and the block-enable word at address 24 within reach. Because the address space runs to 31, the unmapped words 25 to 31 can also be read and written. A constrained-random phase mixes sparse events with random register writes across the whole map. Directed cases cover the event-versus-clear collision, partial and full clears, and each group's line being gated by its own block-enable bit.

// File: rtl/gia_pkg.sv
// Package for the GPIO interrupt aggregator.
// Holds the per-group register selector encoding and the address-width rule.
package gia_pkg;

    // Word offset inside one group's four-word window
    typedef enum logic [1:0] {
        SEL_SOURCE = 2'd0,
        SEL_EN_SET = 2'd1,
        SEL_EN_CLR = 2'd2,
        SEL_RESULT = 2'd3
    } gia_sel_e;

    // Address bits needed for all group windows plus the block-enable word
    function automatic int gia_addr_w(input int groups);
        return $clog2(groups * 4 + 1);
    endfunction

endpackage

// File: rtl/gia_regdec.sv
// Address decoder for the aggregator register port.
// Splits a word address into a group index and a selector, and flags a
// match with one group window or with the block-enable word.
// Assumes: group g occupies words 4*g..4*g+3; block-enable sits at 4*NUM_GROUPS.
module gia_regdec
    import gia_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter int ADDR_W     = gia_addr_w(NUM_GROUPS)
) (
    input  logic [ADDR_W-1:0]     reg_addr,
    output logic [NUM_GROUPS-1:0] grp_sel,
    output gia_sel_e              sel,
    output logic                  blk_sel
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int BLK_ADDR = NUM_GROUPS * 4;

    logic [IDX_W-1:0] grp_idx;

    // Split the address into window index and word offset
    assign grp_idx = reg_addr[ADDR_W-1:2];
    assign sel     = gia_sel_e'(reg_addr[1:0]);
    assign blk_sel = (reg_addr == ADDR_W'(BLK_ADDR));

    // One match flag per group window
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hit
        assign grp_sel[g] = (grp_idx == IDX_W'(g));
    end
endmodule

// File: rtl/gia_group.sv
// One aggregated interrupt group.
// Keeps sticky source bits fed by event pulses, an enable mask changed
// through write-one set/clear strobes, the source AND enable result, and a
// level interrupt gated by this group's block-enable bit.
// Assumes: at most one of the three write strobes is active per cycle.
module gia_group #(
    parameter int BANK_WIDTH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BANK_WIDTH-1:0] evt,
    input  logic                  wr_src_clr,
    input  logic                  wr_en_set,
    input  logic                  wr_en_clr,
    input  logic [BANK_WIDTH-1:0] wdata,
    input  logic                  blk_en,
    output logic [BANK_WIDTH-1:0] src_q,
    output logic [BANK_WIDTH-1:0] en_q,
    output logic [BANK_WIDTH-1:0] result,
    output logic                  irq
);
    logic [BANK_WIDTH-1:0] clr_mask;

    // Bits to clear this cycle from a write-one source write
    assign clr_mask = wr_src_clr ? wdata : '0;

    // Sticky source: clear first, then new events win over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= (src_q & ~clr_mask) | evt;
        end
    end

    // Enable mask: changed only by write-one set or write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en_set) begin
            en_q <= en_q | wdata;
        end else if (wr_en_clr) begin
            en_q <= en_q & ~wdata;
        end
    end

    // Result and gated level interrupt
    assign result = src_q & en_q;
    assign irq    = blk_en & (|result);
endmodule

// File: rtl/gpio_irq_aggregator.sv
// GPIO interrupt aggregator top.
// Instantiates one group per bank, the block-enable register, the address
// decoder and the combinational read mux.
// Assumes: NUM_GROUPS <= BANK_WIDTH so block-enable fits one data word;
// pin_event bits are single-cycle pulses from an external edge detector.
module gpio_irq_aggregator
    import gia_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter int BANK_WIDTH = 32,
    parameter int ADDR_W     = gia_addr_w(NUM_GROUPS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_GROUPS*BANK_WIDTH-1:0] pin_event,
    input  logic                             reg_wr,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [BANK_WIDTH-1:0]            reg_wdata,
    output logic [BANK_WIDTH-1:0]            reg_rdata,
    output logic [NUM_GROUPS-1:0]            irq
);
    localparam int TOTAL_W = NUM_GROUPS * BANK_WIDTH;

    logic [NUM_GROUPS-1:0] grp_sel;
    gia_sel_e              sel;
    logic                  blk_sel;
    logic [NUM_GROUPS-1:0] blk_q;

    logic [BANK_WIDTH-1:0] src_arr [NUM_GROUPS];
    logic [BANK_WIDTH-1:0] en_arr  [NUM_GROUPS];
    logic [BANK_WIDTH-1:0] res_arr [NUM_GROUPS];
    logic [TOTAL_W-1:0]    src_flat;
    logic [TOTAL_W-1:0]    en_flat;

    // Address decode shared by reads and writes
    gia_regdec #(
        .NUM_GROUPS(NUM_GROUPS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .reg_addr(reg_addr),
        .grp_sel (grp_sel),
        .sel     (sel),
        .blk_sel (blk_sel)
    );

    // One group per bank
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic wr_hit;
        assign wr_hit = reg_wr & grp_sel[g];

        gia_group #(
            .BANK_WIDTH(BANK_WIDTH)
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (pin_event[g*BANK_WIDTH +: BANK_WIDTH]),
            .wr_src_clr(wr_hit & (sel == SEL_SOURCE)),
            .wr_en_set (wr_hit & (sel == SEL_EN_SET)),
            .wr_en_clr (wr_hit & (sel == SEL_EN_CLR)),
            .wdata     (reg_wdata),
            .blk_en    (blk_q[g]),
            .src_q     (src_arr[g]),
            .en_q      (en_arr[g]),
            .result    (res_arr[g]),
            .irq       (irq[g])
        );

        assign src_flat[g*BANK_WIDTH +: BANK_WIDTH] = src_arr[g];
        assign en_flat[g*BANK_WIDTH +: BANK_WIDTH]  = en_arr[g];
    end

    // Block-enable register: plain read/write, one bit per group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (reg_wr && blk_sel) begin
            blk_q <= reg_wdata[NUM_GROUPS-1:0];
        end
    end

    // Read mux; unmapped addresses return zero
    always_comb begin
        reg_rdata = '0;
        if (blk_sel) begin
            reg_rdata[NUM_GROUPS-1:0] = blk_q;
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_sel[g]) begin
                case (sel)
                    SEL_SOURCE: reg_rdata = src_arr[g];
                    SEL_EN_SET: reg_rdata = en_arr[g];
                    SEL_EN_CLR: reg_rdata = en_arr[g];
                    SEL_RESULT: reg_rdata = res_arr[g];
                    default:    reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gia_checker.sv
// Assertion checker for the GPIO interrupt aggregator, bound to the top.
module gia_checker #(
    parameter int NUM_GROUPS = 6,
    parameter int BANK_WIDTH = 32,
    parameter int ADDR_W     = 5
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_GROUPS*BANK_WIDTH-1:0] pin_event,
    input logic                             reg_wr,
    input logic [ADDR_W-1:0]                reg_addr,
    input logic [BANK_WIDTH-1:0]            reg_wdata,
    input logic [BANK_WIDTH-1:0]            reg_rdata,
    input logic [NUM_GROUPS-1:0]            irq,
    input logic [NUM_GROUPS*BANK_WIDTH-1:0] src_flat,
    input logic [NUM_GROUPS*BANK_WIDTH-1:0] en_flat,
    input logic [NUM_GROUPS-1:0]            blk_q
);
    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_flat & $past(pin_event)) == $past(pin_event))); // R4

    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_flat & ~$past(src_flat) & ~$past(pin_event)) == '0)); // R2

    AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(en_flat)); // R5

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            !blk_q[g] |-> !irq[g]); // R8

        AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(g*4) && reg_wdata == '1
             && pin_event[g*BANK_WIDTH +: BANK_WIDTH] == '0) |=> !irq[g]); // R10

        AST_EN_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(g*4+1)) |=>
            ((en_flat[g*BANK_WIDTH +: BANK_WIDTH] & $past(reg_wdata)) == $past(reg_wdata))); // R5

        AST_RESULT_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == ADDR_W'(g*4+3)) |->
            (reg_rdata == (src_flat[g*BANK_WIDTH +: BANK_WIDTH] & en_flat[g*BANK_WIDTH +: BANK_WIDTH]))); // R7
    end
endmodule

bind gpio_irq_aggregator gia_checker #(
    .NUM_GROUPS(NUM_GROUPS),
    .BANK_WIDTH(BANK_WIDTH),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_event(pin_event),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .src_flat (src_flat),
    .en_flat  (en_flat),
    .blk_q    (blk_q)
);

// File: tb/gpio_irq_aggregator_test.sv
`timescale 1ns/1ps
module gpio_irq_aggregator_test;
    localparam int NG   = 6;
    localparam int BW   = 32;
    localparam int AW   = 5;
    localparam int BLKA = NG * 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NG*BW-1:0] pin_event = '0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [BW-1:0]   reg_wdata = '0;
    logic [BW-1:0]   reg_rdata;
    logic [NG-1:0]   irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [BW-1:0] m_src [NG];
    logic [BW-1:0] m_en  [NG];
    logic [NG-1:0] m_blk;

    always #2 clk = ~clk;

    gpio_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .pin_event(pin_event), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [NG-1:0] exp_irq();
        logic [NG-1:0] r = '0;
        for (int g = 0; g < NG; g++) r[g] = m_blk[g] & (|(m_src[g] & m_en[g]));
        return r;
    endfunction

    function automatic logic [BW-1:0] exp_read(input logic [AW-1:0] a);
        int g = int'(a) / 4;
        int s = int'(a) % 4;
        if (int'(a) == BLKA) return BW'(m_blk);
        if (g >= NG) return '0;
        case (s)
            0: return m_src[g];
            1, 2: return m_en[g];
            default: return m_src[g] & m_en[g];
        endcase
    endfunction

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, model updates at posedge, irq checked 1 ns later
    task automatic step(input logic wr, input logic [AW-1:0] a, input logic [BW-1:0] d,
                        input logic [NG*BW-1:0] ev);
        reg_wr = wr; reg_addr = a; reg_wdata = d; pin_event = ev;
        @(posedge clk);
        for (int g = 0; g < NG; g++) begin
            logic hit = wr && (int'(a) / 4 == g) && (int'(a) < BLKA);
            int   s   = int'(a) % 4;
            if (hit && s == 0) m_src[g] = m_src[g] & ~d;
            m_src[g] = m_src[g] | ev[g*BW +: BW];
            if (hit && s == 1) m_en[g] = m_en[g] | d;
            if (hit && s == 2) m_en[g] = m_en[g] & ~d;
        end
        if (wr && int'(a) == BLKA) m_blk = d[NG-1:0];
        #1;
        chk("R8 irq level", BW'(irq), BW'(exp_irq()));
        @(negedge clk);
        reg_wr = 1'b0; pin_event = '0;
    endtask

    task automatic rd(input string req, input int a);
        reg_wr = 1'b0; reg_addr = AW'(a); pin_event = '0;
        #1;
        chk(req, reg_rdata, exp_read(AW'(a)));
        step(1'b0, AW'(a), '0, '0);
    endtask

    function automatic logic [NG*BW-1:0] ev1(input int g, input logic [BW-1:0] bits);
        logic [NG*BW-1:0] v = '0;
        v[g*BW +: BW] = bits;
        return v;
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0a61));
        for (int g = 0; g < NG; g++) begin m_src[g] = '0; m_en[g] = '0; end
        m_blk = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every address and line
        chk("R1 irq after reset", BW'(irq), '0);
        for (int a = 0; a < 32; a++) rd("R1 reset read", a);

        // R2: event latches with enable off; result masked
        step(1'b0, '0, '0, ev1(0, 32'h20));
        rd("R2 sticky source", 0);
        rd("R7 result masked", 3);
        // R5: enable set; R8 line held by block-enable
        step(1'b1, AW'(1), 32'h20, '0);
        rd("R7 result", 3);
        chk("R8 blocked line", BW'(irq[0]), 0);
        step(1'b1, AW'(BLKA), 32'h1, '0);
        chk("R8 line up", BW'(irq[0]), 1);
        rd("R9 block-enable read", BLKA);
        // R3: zero write to source changes nothing
        step(1'b1, AW'(0), '0, '0);
        rd("R3 zero write", 0);
        // R9: both enable addresses read the mask
        rd("R9 set addr read", 1);
        rd("R9 clear addr read", 2);
        // R11: partial clear leaves line up
        step(1'b1, AW'(1), 32'h200, ev1(0, 32'h200));
        step(1'b1, AW'(0), 32'h20, '0);
        chk("R11 partial clear", BW'(irq[0]), 1);
        rd("R11 remaining source", 0);
        // R10: clear-all
        step(1'b1, AW'(0), '1, '0);
        chk("R10 full clear irq", BW'(irq[0]), 0);
        rd("R10 source empty", 0);
        // R4: event and clear on same bit
        step(1'b1, AW'(0), 32'h8, ev1(0, 32'h8));
        rd("R4 event wins", 0);
        // R6: enable clear, zero writes ignored
        step(1'b1, AW'(2), '0, '0);
        rd("R6 zero clear", 1);
        step(1'b1, AW'(1), '0, '0);
        rd("R5 zero set", 1);
        step(1'b1, AW'(2), 32'h200, '0);
        rd("R6 enable cleared", 2);
        // R7: write to result ignored
        step(1'b1, AW'(3), '1, '0);
        rd("R7 result write ignored src", 0);
        rd("R7 result write ignored en", 1);
        // R9: unmapped write ignored, read zero
        step(1'b1, AW'(29), '1, '0);
        for (int a = 0; a < 32; a++) rd("R9 map after unmapped write", a);
        // R2: last group, top bit
        step(1'b0, '0, '0, ev1(NG-1, 32'h8000_0000));
        step(1'b1, AW'((NG-1)*4+1), 32'h8000_0000, '0);
        step(1'b1, AW'(BLKA), 32'h20, '0);
        chk("R2 top bit last group", BW'(irq[NG-1]), 1);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic [NG*BW-1:0] ev = '0;
            logic [AW-1:0] a = AW'($urandom_range(0, 31));
            logic [BW-1:0] d;
            int k = $urandom_range(0, 3);
            d = (k == 0) ? '1 : (k == 1) ? $urandom() : ($urandom() & $urandom());
            if ($urandom_range(0, 2) == 0)
                for (int g = 0; g < NG; g++) ev[g*BW +: BW] = $urandom() & $urandom() & $urandom() & $urandom();
            step($urandom_range(0, 1) == 1, a, d, ev);
            if (i % 4 == 0) rd("R9 random read", $urandom_range(0, 31));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule